// File: doc/BRIEF.md
# Performance Measurement Counter Unit

The unit watches a set of per-cycle event strobes from a processor core and its system bus, and accumulates a chosen event class on each of four measurement channels. Each channel is opened and closed by trigger pulses from external comparators. It can instead be opened by the rising edge of a run flag and closed by the first break hit. The result of each channel is a wrapping counter with a sticky overflow flag.

Two neighbouring channels can be joined into one counter of double width. In that case the lower channel supplies the event selection and the gating, and the upper channel holds the high half. Counting follows the core clock enable, so all measurement state freezes while the core sleeps.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset every count output is zero and every overflow flag is clear.
- R2: A channel with both a start and an end trigger configured counts in each enabled cycle after the cycle of its start-hit pulse, up to and including the cycle of its end-hit pulse. It does not count before the start hit or after the end hit.
- R3: A channel with neither trigger configured becomes active on the clock edge at which the run flag is seen rising. It counts in the following cycles, up to and including the cycle in which the break-hit input is high, and then stops.
- R4: A channel with exactly one of start or end configured never counts.
- R5: Each channel has a 4-bit mode code that selects the increment per counted cycle. The codes are:
  - 0: none.
  - 1: one per cycle.
  - 2: instructions issued (0..2) minus the dual-issue strobe.
  - 3: dual-issue strobe.
  - 4: two per branch strobe.
  - 5: exception strobe.
  - 6: cache access strobe.
  - 7: cache miss strobe.
  - 8: wait-cycle strobe.
  - 9: XY move.
  - 10: bus request wait.
  - 11: bus response wait.
  - 12 to 15: none.
- R6: Modes 10 and 11 count only on channels 2 and 3. On channels 0 and 1 they add nothing.
- R7: In modes 10 and 11 a cycle adds exactly 1 when any of the request (or response) wait lines is high, however many are high.
- R8: In mode 9 a cycle adds 1 when the XY read strobe, the XY write strobe or both are high.
- R9: While the clock enable is low, no counter, overflow flag or trigger state changes, apart from init.
- R10: An init bit clears that channel's count and overflow flag and makes the channel inactive. In a joined pair, the init bit of either channel clears the whole pair. Other channels are untouched.
- R11: A counter that passes its maximum wraps modulo its width and sets a sticky overflow flag. The flag stays set until init.
- R12: Extend bit 0 joins channels 0 (low half) and 1 (high half), and extend bit 1 joins channels 2 and 3. The joined counter uses the lower channel's mode and triggers. Its overflow is reported on the upper channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Core clock enable; low while sleeping |
| run | input | 1 | Program running flag |
| brk_hit | input | 1 | Any break condition satisfied |
| ev_issue | input | 2 | Instructions issued this cycle (0..2) |
| ev_dual | input | 1 | Dual issue this cycle |
| ev_branch | input | 1 | Branch taken |
| ev_exc | input | 1 | Exception accepted |
| ev_cache_acc | input | 1 | Cache access |
| ev_cache_miss | input | 1 | Cache miss |
| ev_wait | input | 1 | Memory wait cycle |
| ev_xy_rd | input | 1 | XY memory read move |
| ev_xy_wr | input | 1 | XY memory write move |
| ev_req_wait | input | NWAIT | Bus requests waiting for grant |
| ev_rsp_wait | input | NWAIT | Bus responses waiting for grant |
| start_hit | input | 4 | Start trigger pulse per channel |
| end_hit | input | 4 | End trigger pulse per channel |
| start_cfg | input | 4 | Start trigger configured per channel |
| end_cfg | input | 4 | End trigger configured per channel |
| mode_sel | input | 16 | 4-bit mode per channel, channel c at bits 4c+3..4c |
| ext_en | input | 2 | Join pair (bit 0: ch0/ch1, bit 1: ch2/ch3) |
| init | input | 4 | Clear command per channel |
| count | output | 4*CW | Counter per channel, channel c at bits CW*c+CW-1..CW*c |
| ovf | output | 4 | Sticky overflow per channel |

## Verification
The bench sweeps every mode code on all four channels over several event patterns, so that each code sees both idle and asserted strobes. The patterns include several wait lines at once and both XY moves at once. A unit that summed the wait lines or added the two XY moves would report a larger count. A unit that let bus-wait modes through on the lower channels would show non-zero counts there. The trigger windows are checked at their edges: the start-hit cycle must be excluded and the end-hit or break cycle included, so an off-by-one register in the gate shifts the count by one. A narrow counter width makes wrap and a carry across a joined pair reachable. This exposes a lost carry, a flag that is not sticky, or an init that fails to reach the upper half.

// File: rtl/perf_pkg.sv
package perf_pkg;
    localparam logic [3:0] M_OFF    = 4'd0;
    localparam logic [3:0] M_CYCLE  = 4'd1;
    localparam logic [3:0] M_INSN   = 4'd2;
    localparam logic [3:0] M_DUAL   = 4'd3;
    localparam logic [3:0] M_BRANCH = 4'd4;
    localparam logic [3:0] M_EXC    = 4'd5;
    localparam logic [3:0] M_CACC   = 4'd6;
    localparam logic [3:0] M_CMISS  = 4'd7;
    localparam logic [3:0] M_WAIT   = 4'd8;
    localparam logic [3:0] M_XY     = 4'd9;
    localparam logic [3:0] M_REQW   = 4'd10;
    localparam logic [3:0] M_RSPW   = 4'd11;

    localparam int INC_W = 2;

    typedef struct packed {
        logic [1:0] issue;
        logic       dual;
        logic       branch;
        logic       exc;
        logic       cacc;
        logic       cmiss;
        logic       waitc;
        logic       xy_rd;
        logic       xy_wr;
        logic       req_any;
        logic       rsp_any;
    } ev_t;
endpackage

// File: rtl/perf_inc.sv
module perf_inc
    import perf_pkg::*;
#(
    parameter bit SYSBUS_OK = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         mode,
    input  ev_t                ev,
    output logic [INC_W-1:0]   inc
);
    always_comb begin
        inc = '0;
        case (mode)
            M_CYCLE:  inc = 2'd1;
            M_INSN:   inc = (ev.issue == 2'd0) ? 2'd0 : ev.issue - {1'b0, ev.dual};
            M_DUAL:   inc = {1'b0, ev.dual};
            M_BRANCH: inc = {ev.branch, 1'b0};
            M_EXC:    inc = {1'b0, ev.exc};
            M_CACC:   inc = {1'b0, ev.cacc};
            M_CMISS:  inc = {1'b0, ev.cmiss};
            M_WAIT:   inc = {1'b0, ev.waitc};
            M_XY:     inc = {1'b0, ev.xy_rd | ev.xy_wr};
            M_REQW:   inc = {1'b0, SYSBUS_OK & ev.req_any};
            M_RSPW:   inc = {1'b0, SYSBUS_OK & ev.rsp_any};
            default:  inc = '0;
        endcase
    end

    // R5: no mode ever adds more than two per cycle
    assert_inc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inc <= 2'd2);
endmodule

// File: rtl/perf_gate.sv
module perf_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic run,
    input  logic brk_hit,
    input  logic start_hit,
    input  logic end_hit,
    input  logic start_cfg,
    input  logic end_cfg,
    input  logic init,
    output logic active
);
    typedef struct packed {
        logic active;
        logic run_q;
    } gate_t;

    gate_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (init) begin
            st_d.active = 1'b0;
        end
        if (clk_en) begin
            st_d.run_q = run;
            if (init) begin
                st_d.active = 1'b0;
            end else if (start_cfg && end_cfg) begin
                if (!st_q.active && start_hit)    st_d.active = 1'b1;
                else if (st_q.active && end_hit)  st_d.active = 1'b0;
            end else if (!start_cfg && !end_cfg) begin
                if (!st_q.active && run && !st_q.run_q) st_d.active = 1'b1;
                else if (st_q.active && brk_hit)        st_d.active = 1'b0;
            end else begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    // R4: a half-configured channel is idle after any enabled cycle
    assert_half_cfg_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && (start_cfg != end_cfg)) |=> !active);
    // R9: trigger state frozen while the clock enable is low
    assert_gate_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !init) |=> $stable(active));
endmodule

// File: rtl/perf_pair.sv
module perf_pair
    import perf_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext,
    input  logic             en_lo,
    input  logic             en_hi,
    input  logic [INC_W-1:0] inc_lo,
    input  logic [INC_W-1:0] inc_hi,
    input  logic             init_lo,
    input  logic             init_hi,
    output logic [CW-1:0]    cnt_lo,
    output logic [CW-1:0]    cnt_hi,
    output logic             ovf_lo,
    output logic             ovf_hi
);
    localparam int WW = 2 * CW;

    typedef struct packed {
        logic [CW-1:0] lo;
        logic [CW-1:0] hi;
        logic          ovf_lo;
        logic          ovf_hi;
    } pair_t;

    pair_t pr_q, pr_d;
    logic [WW:0] sum_w;
    logic [CW:0] sum_l, sum_h;

    always_comb begin
        pr_d  = pr_q;
        sum_w = {1'b0, pr_q.hi, pr_q.lo} + {{(WW-INC_W+1){1'b0}}, inc_lo};
        sum_l = {1'b0, pr_q.lo} + {{(CW-INC_W+1){1'b0}}, inc_lo};
        sum_h = {1'b0, pr_q.hi} + {{(CW-INC_W+1){1'b0}}, inc_hi};
        if (ext) begin
            if (init_lo || init_hi) begin
                pr_d = '0;
            end else if (en_lo) begin
                {pr_d.hi, pr_d.lo} = sum_w[WW-1:0];
                pr_d.ovf_hi        = pr_q.ovf_hi | sum_w[WW];
            end
        end else begin
            if (init_lo) begin
                pr_d.lo     = '0;
                pr_d.ovf_lo = 1'b0;
            end else if (en_lo) begin
                pr_d.lo     = sum_l[CW-1:0];
                pr_d.ovf_lo = pr_q.ovf_lo | sum_l[CW];
            end
            if (init_hi) begin
                pr_d.hi     = '0;
                pr_d.ovf_hi = 1'b0;
            end else if (en_hi) begin
                pr_d.hi     = sum_h[CW-1:0];
                pr_d.ovf_hi = pr_q.ovf_hi | sum_h[CW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    assign cnt_lo = pr_q.lo;
    assign cnt_hi = pr_q.hi;
    assign ovf_lo = pr_q.ovf_lo;
    assign ovf_hi = pr_q.ovf_hi;

    // R11: overflow flags are sticky until init
    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hi && !init_hi && !init_lo) |=> ovf_hi);
    // R10: init of the low channel zeroes it on the next edge
    assert_init_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_lo |=> (cnt_lo == '0));
    // R2: an idle pair holds its counts
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_lo && !en_hi && !init_lo && !init_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import perf_pkg::*;
#(
    parameter int CW           = 32,
    parameter int NWAIT        = 4,
    parameter int N_PAIRS      = 2,
    parameter int SYSBUS_FIRST = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en,
    input  logic                  run,
    input  logic                  brk_hit,
    input  logic [1:0]            ev_issue,
    input  logic                  ev_dual,
    input  logic                  ev_branch,
    input  logic                  ev_exc,
    input  logic                  ev_cache_acc,
    input  logic                  ev_cache_miss,
    input  logic                  ev_wait,
    input  logic                  ev_xy_rd,
    input  logic                  ev_xy_wr,
    input  logic [NWAIT-1:0]      ev_req_wait,
    input  logic [NWAIT-1:0]      ev_rsp_wait,
    input  logic [2*N_PAIRS-1:0]  start_hit,
    input  logic [2*N_PAIRS-1:0]  end_hit,
    input  logic [2*N_PAIRS-1:0]  start_cfg,
    input  logic [2*N_PAIRS-1:0]  end_cfg,
    input  logic [8*N_PAIRS-1:0]  mode_sel,
    input  logic [N_PAIRS-1:0]    ext_en,
    input  logic [2*N_PAIRS-1:0]  init,
    output logic [2*N_PAIRS*CW-1:0] count,
    output logic [2*N_PAIRS-1:0]  ovf
);
    localparam int NCH = 2 * N_PAIRS;

    ev_t ev;
    logic [NCH-1:0]   active;
    logic [NCH-1:0]   cnt_en;
    logic [INC_W-1:0] inc [NCH];

    always_comb begin
        ev.issue   = ev_issue;
        ev.dual    = ev_dual;
        ev.branch  = ev_branch;
        ev.exc     = ev_exc;
        ev.cacc    = ev_cache_acc;
        ev.cmiss   = ev_cache_miss;
        ev.waitc   = ev_wait;
        ev.xy_rd   = ev_xy_rd;
        ev.xy_wr   = ev_xy_wr;
        ev.req_any = |ev_req_wait;
        ev.rsp_any = |ev_rsp_wait;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        perf_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .clk_en    (clk_en),
            .run       (run),
            .brk_hit   (brk_hit),
            .start_hit (start_hit[c]),
            .end_hit   (end_hit[c]),
            .start_cfg (start_cfg[c]),
            .end_cfg   (end_cfg[c]),
            .init      (init[c]),
            .active    (active[c])
        );
        perf_inc #(.SYSBUS_OK(c >= SYSBUS_FIRST)) u_inc (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode_sel[4*c +: 4]),
            .ev    (ev),
            .inc   (inc[c])
        );
        assign cnt_en[c] = active[c] & clk_en & ~init[c];
    end

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        perf_pair #(.CW(CW)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .ext     (ext_en[p]),
            .en_lo   (cnt_en[2*p]),
            .en_hi   (cnt_en[2*p+1]),
            .inc_lo  (inc[2*p]),
            .inc_hi  (inc[2*p+1]),
            .init_lo (init[2*p]),
            .init_hi (init[2*p+1]),
            .cnt_lo  (count[(2*p)*CW +: CW]),
            .cnt_hi  (count[(2*p+1)*CW +: CW]),
            .ovf_lo  (ovf[2*p]),
            .ovf_hi  (ovf[2*p+1])
        );
    end

    // R9: counts frozen while the clock enable is low and no init
    assert_cnt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && (init == '0)) |=> ($stable(count) && $stable(ovf)));
endmodule

// File: tb/perf_counter_unit_tb_top.sv
module perf_counter_unit_tb_top;
    localparam int CW = 8;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en, run, brk_hit;
    logic [1:0] ev_issue;
    logic ev_dual, ev_branch, ev_exc, ev_cache_acc, ev_cache_miss, ev_wait, ev_xy_rd, ev_xy_wr;
    logic [NW-1:0] ev_req_wait, ev_rsp_wait;
    logic [3:0] start_hit, end_hit, start_cfg, end_cfg, init, ovf;
    logic [15:0] mode_sel;
    logic [1:0] ext_en;
    logic [4*CW-1:0] count;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    perf_counter_unit #(.CW(CW), .NWAIT(NW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .run(run), .brk_hit(brk_hit),
        .ev_issue(ev_issue), .ev_dual(ev_dual), .ev_branch(ev_branch), .ev_exc(ev_exc),
        .ev_cache_acc(ev_cache_acc), .ev_cache_miss(ev_cache_miss), .ev_wait(ev_wait),
        .ev_xy_rd(ev_xy_rd), .ev_xy_wr(ev_xy_wr), .ev_req_wait(ev_req_wait),
        .ev_rsp_wait(ev_rsp_wait), .start_hit(start_hit), .end_hit(end_hit),
        .start_cfg(start_cfg), .end_cfg(end_cfg), .mode_sel(mode_sel), .ext_en(ext_en),
        .init(init), .count(count), .ovf(ovf)
    );

    function automatic int getc(input int ch);
        return int'(count[ch*CW +: CW]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic window(input logic [3:0] m, input int n);
        start_hit = m; step(); start_hit = '0;
        repeat (n - 1) step();
        end_hit = m; step(); end_hit = '0;
        step(); step();
    endtask

    task automatic clear_all();
        init = 4'hF; step(); init = '0;
    endtask

    task automatic set_pat(input int p);
        {ev_issue, ev_dual, ev_branch, ev_exc, ev_cache_acc, ev_cache_miss, ev_wait, ev_xy_rd, ev_xy_wr} = '0;
        ev_req_wait = '0; ev_rsp_wait = '0;
        case (p)
            1: begin
                ev_issue = 2; ev_dual = 1; ev_branch = 1; ev_exc = 1; ev_cache_acc = 1;
                ev_cache_miss = 1; ev_wait = 1; ev_xy_rd = 1; ev_xy_wr = 1;
                ev_req_wait = 4'b1111; ev_rsp_wait = 4'b1111;
            end
            2: begin
                ev_issue = 2; ev_branch = 1; ev_cache_acc = 1; ev_wait = 1; ev_xy_rd = 1;
                ev_req_wait = 4'b0100;
            end
            3: begin
                ev_issue = 1; ev_exc = 1; ev_cache_miss = 1; ev_xy_wr = 1;
                ev_rsp_wait = 4'b0011;
            end
            default: ;
        endcase
    endtask

    function automatic int exp_inc(input int m, input int ch);
        case (m)
            1: return 1;
            2: return (ev_issue == 0) ? 0 : int'(ev_issue) - int'(ev_dual);
            3: return int'(ev_dual);
            4: return 2 * int'(ev_branch);
            5: return int'(ev_exc);
            6: return int'(ev_cache_acc);
            7: return int'(ev_cache_miss);
            8: return int'(ev_wait);
            9: return (ev_xy_rd || ev_xy_wr) ? 1 : 0;
            10: return (ch >= 2 && ev_req_wait != 0) ? 1 : 0;
            11: return (ch >= 2 && ev_rsp_wait != 0) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_for(input int m, input int ch);
        if (m == 10 || m == 11) return (ch < 2) ? "R6" : "R7";
        if (m == 9) return "R8";
        return "R5";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clk_en = 1; run = 0; brk_hit = 0;
        start_hit = '0; end_hit = '0; start_cfg = 4'hF; end_cfg = 4'hF;
        init = '0; mode_sel = '0; ext_en = '0;
        set_pat(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1: reset state
        for (int c = 0; c < 4; c++) chk("R1 count", getc(c), 0);
        chk("R1 ovf", int'(ovf), 0);

        // R5 R6 R7 R8: mode sweep on all channels over patterns
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 16; m++) begin
                set_pat(p);
                for (int c = 0; c < 4; c++) mode_sel[4*c +: 4] = 4'(m);
                clear_all();
                window(4'hF, 5);
                for (int c = 0; c < 4; c++) chk(tag_for(m, c), getc(c), 5 * exp_inc(m, c));
            end
        end

        // R2: window edges, no count after end
        set_pat(0);
        mode_sel = {4{4'd1}};
        clear_all();
        step();
        chk("R2 before start", getc(0), 0);
        window(4'b0001, 11);
        repeat (4) step();
        chk("R2 window", getc(0), 11);
        chk("R2 other idle", getc(1), 0);

        // R4: only one trigger configured
        clear_all();
        start_cfg = 4'b1110; end_cfg = 4'b1111;
        start_hit = 4'b0011; step(); start_hit = '0;
        repeat (5) step();
        end_hit = 4'b0011; step(); end_hit = '0;
        chk("R4 start only", getc(0), 0);
        chk("R4 control", getc(1), 6);
        clear_all();
        start_cfg = 4'b1111; end_cfg = 4'b1110;
        window(4'b0001, 5);
        chk("R4 end only", getc(0), 0);

        // R3: no triggers, run rise to break
        clear_all();
        start_cfg = 4'b1110; end_cfg = 4'b1110;
        run = 1; step();
        repeat (5) step();
        brk_hit = 1; step(); brk_hit = 0;
        repeat (4) step();
        chk("R3 run to break", getc(0), 6);
        run = 0; step();
        start_cfg = 4'hF; end_cfg = 4'hF;

        // R9: clock enable low freezes counting
        clear_all();
        start_hit = 4'b0001; step(); start_hit = '0;
        repeat (3) step();
        clk_en = 0;
        repeat (4) step();
        chk("R9 frozen", getc(0), 3);
        clk_en = 1;
        repeat (2) step();
        end_hit = 4'b0001; step(); end_hit = '0;
        step();
        chk("R9 resumed", getc(0), 6);

        // R10: init clears one channel only
        clear_all();
        window(4'b0011, 7);
        init = 4'b0001; step(); init = '0;
        chk("R10 cleared", getc(0), 0);
        chk("R10 neighbour", getc(1), 7);

        // R11: wrap and sticky overflow on an unjoined channel
        clear_all();
        window(4'b0100, 260);
        chk("R11 wrap", getc(2), 4);
        chk("R11 ovf set", int'(ovf[2]), 1);
        chk("R11 ovf other", int'(ovf[3]), 0);
        window(4'b0100, 3);
        chk("R11 sticky", int'(ovf[2]), 1);
        init = 4'b0100; step(); init = '0;
        chk("R10 ovf clear", int'(ovf[2]), 0);

        // R12: join ch0/ch1, branch mode adds two
        clear_all();
        ext_en = 2'b01;
        set_pat(2);
        mode_sel = {4'd1, 4'd1, 4'd1, 4'd4};
        window(4'b0001, 200);
        chk("R12 low half", getc(0), 144);
        chk("R12 high half", getc(1), 1);
        chk("R12 no ovf", int'(ovf[1:0]), 0);
        window(4'b0001, 32768);
        chk("R12 pair wrap low", getc(0), 144);
        chk("R12 pair wrap high", getc(1), 1);
        chk("R11 pair ovf", int'(ovf[1:0]), 2);
        init = 4'b0010; step(); init = '0;
        chk("R10 pair init", getc(0) + getc(1) + int'(ovf[1]), 0);

        // R12: join ch2/ch3
        ext_en = 2'b10;
        set_pat(0);
        clear_all();
        window(4'b0100, 300);
        chk("R12 pair1 low", getc(2), 44);
        chk("R12 pair1 high", getc(3), 1);
        chk("R12 pair1 ovf", int'(ovf[3]), 0);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule